// File: doc/BRIEF.md
# 16-bit Up/Down Timer Counter with Atomic Byte Access

This block is a 16-bit timer counter that a CPU reaches over an 8-bit data bus. The bus sees the counter at two byte addresses. Access to the upper byte never touches the counter itself. It goes through a shared 8-bit holding latch instead. Reading the lower byte snapshots the counter's upper byte into that latch in the same cycle. Writing the lower byte loads the whole counter from the written byte and the latch together. Software therefore reads the lower byte first and then the upper byte, and writes the upper byte first and then the lower byte. Either way the 16-bit value is moved in one indivisible step.

Counting is driven by a one-cycle enable pulse from an upstream prescaler or edge detector. That pulse is qualified by a 3-bit source-select field, and the value zero in that field stops the timer. Mode logic outside the block supplies a direction input and a clear input. The block reports when the count is zero and when it matches a supplied maximum. It also keeps a sticky overflow flag, which is set when an upward count wraps around and is cleared by a dedicated input. Everything runs on one system clock.

Top module: `tmr16_bytelatch`

## Requirements
- R1: After reset the counter, the holding latch and the overflow flag are all zero.
- R2: A read with `bus_addr`=1 (upper byte) returns the holding latch. A write with `bus_addr`=1 loads the latch only, and the counter keeps its value.
- R3: A read with `bus_addr`=0 (lower byte) returns the counter's low byte. At the same clock edge it copies the counter's current high byte into the latch.
- R4: A write with `bus_addr`=0 sets the counter to {latch, written byte} in a single clock edge.
- R5: On a qualified tick the counter adds one when `count_down`=0 and subtracts one when `count_down`=1, wrapping modulo 65536.
- R6: While `clk_sel` is 0 the ticks are ignored and the counter holds. Bus reads and writes still work normally.
- R7: On a qualified tick with `clear_req`=1 the counter becomes zero, whatever the direction.
- R8: A lower-byte write takes effect in place of any clear or count in the same cycle.
- R9: The overflow flag sets when a qualified upward count moves the counter from 0xFFFF to 0x0000. A downward wrap does not set it. Once set, it stays set.
- R10: `ovf_clr`=1 clears the flag at the next edge, except when R9 sets the flag in that same cycle, in which case the set wins.
- R11: `at_bottom` is 1 exactly when the counter is 0. `at_top` is 1 exactly when the counter equals `top_value`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_sel | input | 3 | Tick source select; 0 stops the timer |
| tick | input | 1 | One-cycle count-enable pulse from prescaler/edge detector |
| count_down | input | 1 | 1 = decrement, 0 = increment |
| clear_req | input | 1 | Clear the counter on the next qualified tick |
| top_value | input | 16 | Maximum value compared for `at_top` |
| bus_addr | input | 1 | 0 = low byte location, 1 = high byte location |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the selected location |
| ovf_clr | input | 1 | Clear the overflow flag |
| at_top | output | 1 | Counter equals `top_value` |
| at_bottom | output | 1 | Counter equals zero |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
`bus_rdata`, `at_top` and `at_bottom` are combinational from the current state, so they are compared in the same cycle the stimulus is applied. Counter, latch and flag updates are due one edge later, and they show up at the ports in the next cycle. The bench changes its inputs on the falling edge and compares the outputs 1 ns later. It advances its reference model only at the rising edge. As a result, every comparison checks the state that the previous edge produced.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;

    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic {
        LOC_LO = 1'b0,
        LOC_HI = 1'b1
    } byte_loc_e;

    typedef struct packed {
        cnt_t count;
        logic ovf;
    } core_st_t;
endpackage

// File: rtl/tmr16_tick_gate.sv
module tmr16_tick_gate #(
    parameter int SEL_W = 3
) (
    input  logic             tick,
    input  logic [SEL_W-1:0] clk_sel,
    output logic             tick_q
);
    // a zero select field means no source: the timer is stopped
    always_comb begin
        tick_q = tick && (clk_sel != '0);
    end
endmodule

// File: rtl/tmr16_hi_latch.sv
module tmr16_hi_latch
    import tmr16_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  ld_cpu,
    input  byte_t cpu_byte,
    input  logic  ld_snap,
    input  byte_t snap_byte,
    output byte_t temp_q
);
    byte_t temp_d;

    always_comb begin
        temp_d = temp_q;
        if (ld_cpu) begin
            temp_d = cpu_byte;
        end else if (ld_snap) begin
            temp_d = snap_byte;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            temp_q <= '0;
        end else begin
            temp_q <= temp_d;
        end
    end

    // R2: a CPU load reaches the latch one edge later
    a_r2_latch_load: assert property (@(posedge clk) disable iff (!rst_n)
        ld_cpu |=> (temp_q == $past(cpu_byte)));
endmodule

// File: rtl/tmr16_count_core.sv
module tmr16_count_core
    import tmr16_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick_q,
    input  logic dir_down,
    input  logic clr,
    input  logic load,
    input  cnt_t load_val,
    input  logic ovf_clr,
    output cnt_t count_q,
    output logic ovf_q
);
    core_st_t st_d, st_q;
    logic     wrap_up;

    always_comb begin
        st_d    = st_q;
        wrap_up = 1'b0;
        if (load) begin
            st_d.count = load_val;
        end else if (tick_q) begin
            if (clr) begin
                st_d.count = '0;
            end else if (dir_down) begin
                st_d.count = st_q.count - 1'b1;
            end else begin
                st_d.count = st_q.count + 1'b1;
                wrap_up    = (st_q.count == '1);
            end
        end
        if (wrap_up) begin
            st_d.ovf = 1'b1;
        end else if (ovf_clr) begin
            st_d.ovf = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_q = st_q.count;
    assign ovf_q   = st_q.ovf;

    a_r8_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (count_q == $past(load_val)));

    a_r6_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_q && !load) |=> $stable(count_q));

    a_r7_clear_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_q && clr && !load) |=> (count_q == '0));

    a_r9_overflow_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_q && !clr && !dir_down && !load && count_q == '1) |=> (ovf_q && count_q == '0));

    a_r10_flag_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_clr && !tick_q) |=> !ovf_q);

    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !ovf_clr) |=> ovf_q);
endmodule

// File: rtl/tmr16_bytelatch.sv
module tmr16_bytelatch
    import tmr16_pkg::*;
#(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] clk_sel,
    input  logic             tick,
    input  logic             count_down,
    input  logic             clear_req,
    input  logic [CNT_W-1:0] top_value,
    input  logic             bus_addr,
    input  logic             bus_rd,
    input  logic             bus_wr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic             ovf_clr,
    output logic             at_top,
    output logic             at_bottom,
    output logic             ovf_flag
);
    logic  tick_q;
    logic  wr_lo, wr_hi, rd_lo;
    byte_t temp_q;
    cnt_t  count_q;

    always_comb begin
        wr_lo = bus_wr && (byte_loc_e'(bus_addr) == LOC_LO);
        wr_hi = bus_wr && (byte_loc_e'(bus_addr) == LOC_HI);
        rd_lo = bus_rd && (byte_loc_e'(bus_addr) == LOC_LO);
    end

    tmr16_tick_gate #(.SEL_W(SEL_W)) u_gate (
        .tick    (tick),
        .clk_sel (clk_sel),
        .tick_q  (tick_q)
    );

    tmr16_hi_latch u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_cpu    (wr_hi),
        .cpu_byte  (bus_wdata),
        .ld_snap   (rd_lo),
        .snap_byte (count_q[CNT_W-1:BYTE_W]),
        .temp_q    (temp_q)
    );

    tmr16_count_core u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_q   (tick_q),
        .dir_down (count_down),
        .clr      (clear_req),
        .load     (wr_lo),
        .load_val ({temp_q, bus_wdata}),
        .ovf_clr  (ovf_clr),
        .count_q  (count_q),
        .ovf_q    (ovf_flag)
    );

    always_comb begin
        if (byte_loc_e'(bus_addr) == LOC_HI) begin
            bus_rdata = temp_q;
        end else begin
            bus_rdata = count_q[BYTE_W-1:0];
        end
        at_bottom = (count_q == '0);
        at_top    = (count_q == top_value);
    end

    a_r3_snapshot_high: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lo && !bus_wr) |=> (temp_q == $past(count_q[CNT_W-1:BYTE_W])));

    a_r2_high_write_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi && !tick_q) |=> $stable(count_q));

    a_r4_atomic_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> (count_q == {$past(temp_q), $past(bus_wdata)}));
endmodule

// File: tb/tb_tmr16_bytelatch.sv
`timescale 1ns/1ps
module tb_tmr16_bytelatch;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  clk_sel = '0;
    logic        tick = 1'b0, count_down = 1'b0, clear_req = 1'b0;
    logic [15:0] top_value = 16'h1234;
    logic        bus_addr = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        ovf_clr = 1'b0;
    logic        at_top, at_bottom, ovf_flag;

    int unsigned n_vec = 0;
    int unsigned n_bad = 0;
    bit          done = 1'b0;

    logic [15:0] m_cnt;
    logic [7:0]  m_tmp;
    logic        m_ovf;

    always #4 clk = ~clk;

    tmr16_bytelatch dut (
        .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .tick(tick),
        .count_down(count_down), .clear_req(clear_req), .top_value(top_value),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ovf_clr(ovf_clr),
        .at_top(at_top), .at_bottom(at_bottom), .ovf_flag(ovf_flag)
    );

    function automatic logic [15:0] next_cnt(logic [15:0] c, logic [7:0] t);
        if (bus_wr && !bus_addr) return {t, bus_wdata};
        if (tick && clk_sel != 0) begin
            if (clear_req) return 16'h0000;
            return count_down ? c - 16'd1 : c + 16'd1;
        end
        return c;
    endfunction

    function automatic logic [7:0] next_tmp(logic [15:0] c, logic [7:0] t);
        if (bus_wr && bus_addr) return bus_wdata;
        if (bus_rd && !bus_addr) return c[15:8];
        return t;
    endfunction

    function automatic logic next_ovf(logic [15:0] c, logic f);
        if (!(bus_wr && !bus_addr) && tick && clk_sel != 0 && !clear_req
            && !count_down && c == 16'hFFFF) return 1'b1;
        if (ovf_clr) return 1'b0;
        return f;
    endfunction

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic idle();
        bus_rd = 0; bus_wr = 0; tick = 0; clear_req = 0; ovf_clr = 0;
    endtask

    // inputs are set after a falling edge; compare, then cross one rising edge
    task automatic step(string rd_tag);
        logic [15:0] c_n;
        logic [7:0]  t_n;
        logic        f_n;
        #1;
        if (bus_rd)
            check(rd_tag, {8'h00, bus_rdata}, {8'h00, (bus_addr ? m_tmp : m_cnt[7:0])});
        check("R11 bottom", {15'd0, at_bottom}, {15'd0, (m_cnt == 16'h0000)});
        check("R11 top", {15'd0, at_top}, {15'd0, (m_cnt == top_value)});
        check("R9 flag", {15'd0, ovf_flag}, {15'd0, m_ovf});
        c_n = next_cnt(m_cnt, m_tmp);
        t_n = next_tmp(m_cnt, m_tmp);
        f_n = next_ovf(m_cnt, m_ovf);
        @(posedge clk);
        m_cnt = c_n; m_tmp = t_n; m_ovf = f_n;
        @(negedge clk);
        idle();
    endtask

    task automatic wr_byte(logic hi, logic [7:0] d);
        bus_addr = hi; bus_wr = 1; bus_wdata = d;
        step("R4");
    endtask

    task automatic rd_byte(logic hi, string tag);
        bus_addr = hi; bus_rd = 1;
        step(tag);
    endtask

    task automatic load16(logic [15:0] v);
        wr_byte(1'b1, v[15:8]);
        wr_byte(1'b0, v[7:0]);
    endtask

    task automatic tick_n(int n, logic dn, logic [2:0] sel);
        for (int i = 0; i < n; i++) begin
            tick = 1; count_down = dn; clk_sel = sel;
            step("R5");
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        m_cnt = '0; m_tmp = '0; m_ovf = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state seen through the bus
        rd_byte(1'b1, "R1 latch");
        rd_byte(1'b0, "R1 low");
        rd_byte(1'b1, "R1 high");

        // R2 / R4: high write goes to latch only; low write loads both bytes
        wr_byte(1'b1, 8'hA5);
        rd_byte(1'b0, "R2 count unchanged");
        wr_byte(1'b1, 8'hC3);
        rd_byte(1'b1, "R2 latch readback");
        wr_byte(1'b0, 8'h7E);
        rd_byte(1'b0, "R4 low");
        rd_byte(1'b1, "R4 high");

        // R5: up and down counting
        clk_sel = 3'd1;
        tick_n(5, 1'b0, 3'd1);
        rd_byte(1'b0, "R5 up low");
        tick_n(9, 1'b1, 3'd4);
        rd_byte(1'b0, "R5 down low");
        rd_byte(1'b1, "R5 down high");

        // R6: select zero stops counting, bus still works
        tick_n(6, 1'b0, 3'd0);
        rd_byte(1'b0, "R6 low held");
        wr_byte(1'b1, 8'h11);
        rd_byte(1'b1, "R6 bus live");

        // R7: clear beats direction
        tick = 1; clear_req = 1; clk_sel = 3'd2; count_down = 1;
        step("R7");
        rd_byte(1'b0, "R7 cleared low");
        rd_byte(1'b1, "R7 cleared high");

        // R8: low write beats clear and count in the same cycle
        wr_byte(1'b1, 8'h40);
        bus_addr = 0; bus_wr = 1; bus_wdata = 8'h09; tick = 1; clear_req = 1; clk_sel = 3'd3;
        step("R8");
        rd_byte(1'b0, "R8 low");
        rd_byte(1'b1, "R8 high");

        // R9: upward wrap sets flag; R10 clears it; downward wrap leaves it
        load16(16'hFFFE);
        tick_n(2, 1'b0, 3'd5);
        rd_byte(1'b0, "R9 wrapped low");
        ovf_clr = 1;
        step("R10");
        tick_n(1, 1'b1, 3'd5);
        rd_byte(1'b1, "R9 down wrap high");
        load16(16'hFFFF);
        tick = 1; clk_sel = 3'd1; count_down = 0; ovf_clr = 1;
        step("R10 set wins");

        // R11: top match
        top_value = 16'h0203;
        load16(16'h0202);
        tick_n(2, 1'b0, 3'd1);

        // random traffic
        for (int i = 0; i < 4000; i++) begin
            int unsigned r;
            r = $urandom_range(0, 99);
            bus_addr  = $urandom_range(0, 1);
            bus_wdata = 8'($urandom);
            if (r < 30) bus_rd = 1;
            else if (r < 45) bus_wr = 1;
            tick       = ($urandom_range(0, 1) == 1);
            clk_sel    = ($urandom_range(0, 3) == 0) ? 3'd0 : 3'($urandom_range(1, 7));
            count_down = ($urandom_range(0, 9) < 4);
            clear_req  = ($urandom_range(0, 19) == 0);
            ovf_clr    = ($urandom_range(0, 19) == 0);
            if ($urandom_range(0, 7) == 0) top_value = m_cnt;
            if (i % 400 == 0) begin
                idle();
                load16(16'hFFFC);
            end else begin
                step(bus_addr ? "R2" : "R3");
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule